// File: doc/BRIEF.md
# Split-capable bus slave

This block is a slave on a pipelined, high-performance on-chip system bus. A transfer is taken in its address phase, when the decoder select is high and the bus ready is high. Its result appears in the following data phase as read data, a ready flag and a 2-bit response code. The slave holds a small word array. Ordinary (fast) addresses are served with no wait states.

Addresses that the slave classes as slow are not served at once. The first slow access gets a two-cycle SPLIT response, and the slave keeps the requesting master's 2-bit tag. It then runs a fixed internal latency count. When the count runs out, it pulses the bit of its split-completion vector that belongs to that master, so the arbiter can let the master back onto the bus. The master then repeats the access, and that access completes with OKAY.

The slave tracks only one outstanding split at a time. A slow access from any other master in the meantime is turned away with SPLIT.

Top module: `split_slave`

## Requirements
- R1: During and right after reset, ready_o is 1, resp_o is OKAY (2'b00) and split_done_o is all zero.
- R2: A fast access completes with ready_o high and resp_o OKAY in its data phase, with no wait state. A fast access is selected, of type NONSEQ (2'b10) or SEQ (2'b11), with addr_i bit 7 clear. The word is chosen by addr_i[5:2]; bits 6 and 1:0 play no part. Write data is taken in the data phase. Read data is shown in the data phase. A read whose address phase falls in the data phase of a write to the same word returns the new data.
- R3: A cycle with sel_i low, or of type IDLE (2'b00) or BUSY (2'b01), gets a zero-wait OKAY. It never starts a split and never changes the array, whatever the address.
- R4: A slow access (addr_i bit 7 set) with no split outstanding gets SPLIT (2'b11) over two data-phase cycles: ready_o low in the first and high in the second.
- R5: The slave stores the tag of the access that opened the split. split_done_o then has the bit indexed by that tag high for exactly one cycle. That cycle begins at the 8th rising edge after the edge that sampled the slow address. No other bit is ever set.
- R6: A slow access by the stored master before its pulse gets SPLIT again. It does not move the pulse.
- R7: While a split is outstanding, a slow access by any other master gets SPLIT. It does not change the stored tag and does not start a new count.
- R8: After the pulse, a slow access by the stored master completes with a zero-wait OKAY: its read data is returned, or its write is stored. The split is then released, so the next slow access opens a new split.
- R9: A write that got a SPLIT response is never stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_i | input | 1 | Select from the address decoder |
| bus_ready_i | input | 1 | Bus-wide ready; an address is taken only when high |
| trans_i | input | 2 | Transfer type: IDLE 00, BUSY 01, NONSEQ 10, SEQ 11 |
| addr_i | input | 8 | Byte address; bit 7 marks slow |
| write_i | input | 1 | 1 = write, 0 = read |
| wdata_i | input | 32 | Write data, valid in the data phase |
| tag_i | input | 2 | Number of the master owning the address phase |
| rdata_o | output | 32 | Read data |
| ready_o | output | 1 | Data-phase ready |
| resp_o | output | 2 | Response code: OKAY 00, SPLIT 11 |
| split_done_o | output | 4 | One-cycle split-completion pulse, one bit per master tag |

## Verification
ready_o, resp_o and rdata_o all belong to the cycle after the edge that samples an address. The bench drives each address on a falling edge and reads these outputs at the next falling edge. For a SPLIT it reads again one falling edge later to see the second response cycle. A split-completion pulse is due exactly eight rising edges after the sampling edge. A monitor records, on falling edges, the edge count and vector of every pulse. The bench compares these against the count it saved when the slow address was taken. Writes land one edge after their address, so every stored-value check is a later read through the bus.

// File: rtl/splitslv_pkg.sv
package splitslv_pkg;
  typedef enum logic [1:0] {
    TR_IDLE   = 2'b00,
    TR_BUSY   = 2'b01,
    TR_NONSEQ = 2'b10,
    TR_SEQ    = 2'b11
  } xfer_kind_e;

  localparam logic [1:0] RSP_OKAY  = 2'b00;
  localparam logic [1:0] RSP_ERROR = 2'b01;
  localparam logic [1:0] RSP_RETRY = 2'b10;
  localparam logic [1:0] RSP_SPLIT = 2'b11;

  typedef enum logic [1:0] {
    PH_NORMAL = 2'b00,
    PH_DEFER1 = 2'b01,
    PH_DEFER2 = 2'b10
  } phase_e;
endpackage

// File: rtl/splitslv_ram.sv
module splitslv_ram #(
  parameter int WIDTH = 32,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] widx,
  input  logic [WIDTH-1:0] wdata,
  input  logic             re,
  input  logic [IDX_W-1:0] ridx,
  output logic [WIDTH-1:0] q
);
  localparam int DEPTH = 1 << IDX_W;

  logic [WIDTH-1:0] store [DEPTH];

  // Write-first single-clock array: a read of the word being written sees new data.
  always_ff @(posedge clk) begin
    if (we) store[widx] <= wdata;
    if (re) begin
      if (we && (widx == ridx)) q <= wdata;
      else                      q <= store[ridx];
    end
  end
endmodule

// File: rtl/splitslv_tracker.sv
module splitslv_tracker #(
  parameter int TAG_W = 2,
  parameter int LAT   = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     start_i,
  input  logic [TAG_W-1:0]         tag_i,
  input  logic                     finish_i,
  output logic                     pending_o,
  output logic [TAG_W-1:0]         owner_o,
  output logic                     done_o,
  output logic [(1 << TAG_W)-1:0]  pulse_o
);
  localparam int NM    = 1 << TAG_W;
  localparam int CNT_W = $clog2(LAT + 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      pending_o <= 1'b0;
      owner_o   <= '0;
      done_o    <= 1'b0;
      cnt       <= '0;
      pulse_o   <= '0;
    end else begin
      pulse_o <= '0;
      if (start_i) begin
        pending_o <= 1'b1;
        owner_o   <= tag_i;
        done_o    <= 1'b0;
        cnt       <= CNT_W'(LAT);
      end else if (finish_i) begin
        pending_o <= 1'b0;
        done_o    <= 1'b0;
        cnt       <= '0;
      end else if (pending_o && !done_o) begin
        cnt <= cnt - CNT_W'(1);
        if (cnt == CNT_W'(1)) begin
          done_o  <= 1'b1;
          pulse_o <= NM'(1) << owner_o;
        end
      end
    end
  end

  a_r5_pulse_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(pulse_o));

  a_r5_pulse_owner_bit: assert property (@(posedge clk) disable iff (rst)
    (pulse_o != '0) |-> (pending_o && done_o && (pulse_o == (NM'(1) << owner_o))));

  a_r5_pulse_one_cycle: assert property (@(posedge clk) disable iff (rst)
    (pulse_o != '0) |=> (pulse_o == '0));

  a_r7_owner_held: assert property (@(posedge clk) disable iff (rst)
    (pending_o && !finish_i) |=> (pending_o && $stable(owner_o)));

  a_r6_count_bound: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNT_W'(LAT));

  a_r8_done_needs_pending: assert property (@(posedge clk) disable iff (rst)
    done_o |-> pending_o);
endmodule

// File: rtl/splitslv_resp.sv
module splitslv_resp
  import splitslv_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       accept_i,
  input  logic       defer_i,
  output logic       ready_o,
  output logic [1:0] resp_o
);
  phase_e ph;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph      <= PH_NORMAL;
      ready_o <= 1'b1;
      resp_o  <= RSP_OKAY;
    end else begin
      case (ph)
        PH_DEFER1: begin
          ph      <= PH_DEFER2;
          ready_o <= 1'b1;
          resp_o  <= RSP_SPLIT;
        end
        default: begin
          if (accept_i && defer_i) begin
            ph      <= PH_DEFER1;
            ready_o <= 1'b0;
            resp_o  <= RSP_SPLIT;
          end else begin
            ph      <= PH_NORMAL;
            ready_o <= 1'b1;
            resp_o  <= RSP_OKAY;
          end
        end
      endcase
    end
  end

  a_r4_wait_is_split: assert property (@(posedge clk) disable iff (rst)
    !ready_o |-> (resp_o == RSP_SPLIT));

  a_r4_second_split_cycle: assert property (@(posedge clk) disable iff (rst)
    !ready_o |=> (ready_o && resp_o == RSP_SPLIT));

  a_r2_okay_no_wait: assert property (@(posedge clk) disable iff (rst)
    (resp_o == RSP_OKAY) |-> ready_o);
endmodule

// File: rtl/split_slave.sv
module split_slave
  import splitslv_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32,
  parameter int TAG_W    = 2,
  parameter int WORDS    = 16,
  parameter int SLOW_BIT = 7,
  parameter int LAT      = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    sel_i,
  input  logic                    bus_ready_i,
  input  logic [1:0]              trans_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic                    write_i,
  input  logic [DATA_W-1:0]       wdata_i,
  input  logic [TAG_W-1:0]        tag_i,
  output logic [DATA_W-1:0]       rdata_o,
  output logic                    ready_o,
  output logic [1:0]              resp_o,
  output logic [(1 << TAG_W)-1:0] split_done_o
);
  localparam int IDX_W = $clog2(WORDS);
  localparam int NM    = 1 << TAG_W;

  logic             accept, slow, owner_hit, defer, completes;
  logic             start_split, finish_split;
  logic             pending, done;
  logic [TAG_W-1:0] owner;
  logic [IDX_W-1:0] idx;
  logic             wr_q;
  logic [IDX_W-1:0] widx_q;
  logic             unused_bits;

  // Address-phase decode
  assign accept    = sel_i && bus_ready_i && trans_i[1];
  assign slow      = addr_i[SLOW_BIT];
  assign idx       = addr_i[IDX_W+1:2];
  assign owner_hit = pending && done && (tag_i == owner);
  assign defer     = slow && !owner_hit;
  assign completes = accept && !defer;

  assign start_split  = accept && slow && !pending;
  assign finish_split = accept && slow && owner_hit;

  assign unused_bits = ^{addr_i, trans_i};

  // Data-phase write bookkeeping: only accesses that complete are stored
  always_ff @(posedge clk) begin
    if (rst) begin
      wr_q   <= 1'b0;
      widx_q <= '0;
    end else begin
      wr_q <= completes && write_i;
      if (completes) widx_q <= idx;
    end
  end

  splitslv_ram #(
    .WIDTH (DATA_W),
    .IDX_W (IDX_W)
  ) u_ram (
    .clk   (clk),
    .we    (wr_q),
    .widx  (widx_q),
    .wdata (wdata_i),
    .re    (completes && !write_i),
    .ridx  (idx),
    .q     (rdata_o)
  );

  splitslv_tracker #(
    .TAG_W (TAG_W),
    .LAT   (LAT)
  ) u_track (
    .clk       (clk),
    .rst       (rst),
    .start_i   (start_split),
    .tag_i     (tag_i),
    .finish_i  (finish_split),
    .pending_o (pending),
    .owner_o   (owner),
    .done_o    (done),
    .pulse_o   (split_done_o)
  );

  splitslv_resp u_resp (
    .clk      (clk),
    .rst      (rst),
    .accept_i (accept),
    .defer_i  (defer),
    .ready_o  (ready_o),
    .resp_o   (resp_o)
  );

  a_r3_quiet_is_okay: assert property (@(posedge clk) disable iff (rst)
    (ready_o && !(sel_i && trans_i[1])) |=> (ready_o && resp_o == RSP_OKAY));

  a_r9_no_store_on_split: assert property (@(posedge clk) disable iff (rst)
    (resp_o == RSP_SPLIT) |-> !wr_q);

  a_r7_other_master_split: assert property (@(posedge clk) disable iff (rst)
    (ready_o && accept && slow && pending && (tag_i != owner)) |=> (!ready_o && resp_o == RSP_SPLIT));

  a_r5_pulse_only_when_pending: assert property (@(posedge clk) disable iff (rst)
    (split_done_o != '0) |-> (split_done_o[owner] && pending));

  a_r8_owner_completes: assert property (@(posedge clk) disable iff (rst)
    (ready_o && accept && slow && pending && done && (tag_i == owner)) |=> (ready_o && resp_o == RSP_OKAY && !pending));

  initial begin
    a_param_widths: assert (SLOW_BIT > IDX_W + 1 && SLOW_BIT < ADDR_W && LAT >= 1 && NM >= 2);
  end
endmodule

// File: tb/tb_split_slave.sv
module tb_split_slave;
  import splitslv_pkg::*;

  localparam int LAT = 8;

  logic        clk = 1'b0;
  logic        rst;
  logic        sel;
  logic [1:0]  trans;
  logic [7:0]  addr;
  logic        wr;
  logic [31:0] wdata;
  logic [1:0]  tag;
  logic [31:0] rdata;
  logic        ready;
  logic [1:0]  resp;
  logic [3:0]  split_done;

  always #5 clk = ~clk;

  split_slave dut (
    .clk          (clk),
    .rst          (rst),
    .sel_i        (sel),
    .bus_ready_i  (ready),
    .trans_i      (trans),
    .addr_i       (addr),
    .write_i      (wr),
    .wdata_i      (wdata),
    .tag_i        (tag),
    .rdata_o      (rdata),
    .ready_o      (ready),
    .resp_o       (resp),
    .split_done_o (split_done)
  );

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;
  int pulse_n  = 0;
  int pulse_cyc = -1;
  logic [3:0] pulse_vec = '0;
  logic [31:0] model [16];

  logic        r1, r2;
  logic [1:0]  p1, p2;
  logic [31:0] rd;
  int          e0, pc0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (split_done != 4'b0000) begin
      pulse_n   <= pulse_n + 1;
      pulse_cyc <= cyc;
      pulse_vec <= split_done;
    end
  end

  task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  // Called at a falling edge; returns at a falling edge after the transfer settles.
  task automatic xfer(input logic s, input logic [1:0] tr, input logic [7:0] a, input logic w,
                      input logic [31:0] wd, input logic [1:0] t,
                      output logic o_r1, output logic [1:0] o_p1, output logic o_r2,
                      output logic [1:0] o_p2, output logic [31:0] o_rd, output int o_e0);
    sel = s; trans = tr; addr = a; wr = w; tag = t;
    @(posedge clk); @(negedge clk);
    o_e0 = cyc; o_r1 = ready; o_p1 = resp; o_rd = rdata;
    o_r2 = ready; o_p2 = resp;
    sel = 1'b0; trans = TR_IDLE; wdata = wd;
    if (!ready) begin
      @(posedge clk); @(negedge clk);
      o_r2 = ready; o_p2 = resp;
    end
    @(posedge clk); @(negedge clk);
  endtask

  function automatic logic [31:0] pat(input int i, input int salt);
    return (32'h1357_9BDF * (i + 1)) ^ (salt << 24) ^ i;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=finished");
    summary();
  end

  initial begin
    rst = 1'b1; sel = 1'b0; trans = TR_IDLE; addr = '0; wr = 1'b0; wdata = '0; tag = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(ready == 1'b1 && resp == RSP_OKAY && split_done == 4'b0, "R1 reset outputs",
        {ready, resp, split_done}, {1'b1, 2'b00, 4'b0});
    rst = 1'b0;
    @(posedge clk); @(negedge clk);
    chk(ready == 1'b1 && resp == RSP_OKAY && split_done == 4'b0, "R1 after reset",
        {ready, resp, split_done}, {1'b1, 2'b00, 4'b0});

    // R2: fill every word, alternating NONSEQ / SEQ and all tags
    for (int i = 0; i < 16; i++) begin
      model[i] = pat(i, 1);
      xfer(1'b1, (i % 2) ? TR_SEQ : TR_NONSEQ, 8'(i << 2), 1'b1, model[i], 2'(i),
           r1, p1, r2, p2, rd, e0);
      chk(r1 && p1 == RSP_OKAY, "R2 fast write zero wait", {r1, p1}, {1'b1, RSP_OKAY});
    end
    // R2: read back, with the ignored address bits 6 and 1:0 set
    for (int i = 0; i < 16; i++) begin
      xfer(1'b1, (i % 2) ? TR_NONSEQ : TR_SEQ, 8'((i << 2) | 8'h43), 1'b0, 32'h0, 2'(3 - i % 4),
           r1, p1, r2, p2, rd, e0);
      chk(r1 && p1 == RSP_OKAY, "R2 fast read zero wait", {r1, p1}, {1'b1, RSP_OKAY});
      chk(rd == model[i], "R2 fast read data", rd, model[i]);
    end

    // R2: read issued in the data phase of a write to the same word
    sel = 1'b1; trans = TR_NONSEQ; addr = 8'h0C; wr = 1'b1; tag = 2'd1;
    @(posedge clk); @(negedge clk);
    chk(ready && resp == RSP_OKAY, "R2 pipelined write", {ready, resp}, {1'b1, RSP_OKAY});
    model[3] = 32'hBEEF_0003;
    wdata = model[3]; trans = TR_SEQ; wr = 1'b0;
    @(posedge clk); @(negedge clk);
    chk(rdata == model[3], "R2 read after write same word", rdata, model[3]);
    sel = 1'b0; trans = TR_IDLE;
    @(posedge clk); @(negedge clk);

    // R3: quiet cycles never write, never split
    pc0 = pulse_n;
    for (int i = 0; i < 16; i++) begin
      for (int k = 0; k < 3; k++) begin
        xfer(k != 0, (k == 1) ? TR_IDLE : ((k == 2) ? TR_BUSY : TR_NONSEQ),
             8'((i << 2) | ((i % 2) ? 8'h80 : 8'h00)), 1'b1, 32'hDEAD_0000 | 32'(i), 2'(i),
             r1, p1, r2, p2, rd, e0);
        chk(r1 && p1 == RSP_OKAY, "R3 quiet cycle okay", {r1, p1}, {1'b1, RSP_OKAY});
      end
    end
    repeat (LAT + 2) begin @(posedge clk); @(negedge clk); end
    chk(pulse_n == pc0, "R3 no split from quiet cycles", pulse_n, pc0);
    for (int i = 0; i < 16; i++) begin
      xfer(1'b1, TR_NONSEQ, 8'(i << 2), 1'b0, 32'h0, 2'd0, r1, p1, r2, p2, rd, e0);
      chk(rd == model[i], "R3 array unchanged", rd, model[i]);
    end

    // R4..R9 for every master tag
    for (int m = 0; m < 4; m++) begin
      int ix;
      logic [31:0] d1, d2;
      ix = 4 + m;
      d1 = pat(ix, 7);
      d2 = pat(ix, 9);
      pc0 = pulse_n;

      xfer(1'b1, TR_NONSEQ, 8'(8'h80 | (ix << 2)), 1'b1, d1, 2'(m), r1, p1, r2, p2, rd, e0);
      chk(!r1 && p1 == RSP_SPLIT, "R4 split first cycle", {r1, p1}, {1'b0, RSP_SPLIT});
      chk(r2 && p2 == RSP_SPLIT, "R4 split second cycle", {r2, p2}, {1'b1, RSP_SPLIT});
      begin
        int n0;
        n0 = e0;
        xfer(1'b1, TR_SEQ, 8'(8'h80 | (ix << 2)), 1'b0, 32'h0, 2'(m), r1, p1, r2, p2, rd, e0);
        chk(!r1 && p1 == RSP_SPLIT && r2 && p2 == RSP_SPLIT, "R6 early retry split again",
            {r1, p1, r2, p2}, {1'b0, RSP_SPLIT, 1'b1, RSP_SPLIT});
        for (int k = 0; k < 30 && pulse_n == pc0; k++) begin
          @(posedge clk); @(negedge clk);
        end
        chk(pulse_cyc == n0 + LAT, "R5 pulse timing", pulse_cyc, n0 + LAT);
        chk(pulse_vec == 4'(1 << m), "R5 pulse bit", pulse_vec, 4'(1 << m));
        @(posedge clk); @(negedge clk);
        chk(pulse_n == pc0 + 1 && split_done == 4'b0, "R5 pulse single cycle",
            pulse_n, pc0 + 1);
      end

      xfer(1'b1, TR_NONSEQ, 8'(ix << 2), 1'b0, 32'h0, 2'(m), r1, p1, r2, p2, rd, e0);
      chk(rd == model[ix], "R9 split write not stored", rd, model[ix]);

      xfer(1'b1, TR_NONSEQ, 8'(8'h80 | (ix << 2)), 1'b0, 32'h0, 2'((m + 1) % 4),
           r1, p1, r2, p2, rd, e0);
      chk(!r1 && p1 == RSP_SPLIT && r2 && p2 == RSP_SPLIT, "R7 other master split",
          {r1, p1, r2, p2}, {1'b0, RSP_SPLIT, 1'b1, RSP_SPLIT});

      xfer(1'b1, TR_NONSEQ, 8'(8'h80 | (ix << 2)), 1'b1, d2, 2'(m), r1, p1, r2, p2, rd, e0);
      chk(r1 && p1 == RSP_OKAY, "R8 owner completes write", {r1, p1}, {1'b1, RSP_OKAY});
      model[ix] = d2;
      xfer(1'b1, TR_SEQ, 8'(ix << 2), 1'b0, 32'h0, 2'(m), r1, p1, r2, p2, rd, e0);
      chk(rd == d2, "R8 completed write stored", rd, d2);
      repeat (LAT + 2) begin @(posedge clk); @(negedge clk); end
      chk(pulse_n == pc0 + 1, "R7 no count from other master", pulse_n, pc0 + 1);

      // R8: split released, a new slow read splits and then completes with data
      xfer(1'b1, TR_NONSEQ, 8'(8'h80 | (ix << 2)), 1'b0, 32'h0, 2'(m), r1, p1, r2, p2, rd, e0);
      chk(!r1 && p1 == RSP_SPLIT, "R8 released then new split", {r1, p1}, {1'b0, RSP_SPLIT});
      for (int k = 0; k < 30 && pulse_n == pc0 + 1; k++) begin
        @(posedge clk); @(negedge clk);
      end
      chk(pulse_vec == 4'(1 << m) && pulse_cyc == e0 + LAT, "R5 second pulse",
          {pulse_vec, 32'(pulse_cyc)}, {4'(1 << m), 32'(e0 + LAT)});
      xfer(1'b1, TR_NONSEQ, 8'(8'h80 | (ix << 2)), 1'b0, 32'h0, 2'(m), r1, p1, r2, p2, rd, e0);
      chk(r1 && p1 == RSP_OKAY && rd == d2, "R8 owner completes read",
          {r1, p1, rd}, {1'b1, RSP_OKAY, d2});
    end

    summary();
  end
endmodule